// File: doc/BRIEF.md
# Trap and Halt-Mode Entry Sequencer

This block carries out the memory traffic a processor needs when it enters a trap, an interrupt or the privileged halt mode. An arbiter hands it one entry request, made of a kind code and a vector address, on a valid/ready port. The sequencer first reads the system selector register, then writes it back with the halt-mode bit set or cleared. Next it saves the current program counter and status word. For a normal entry these two words are pushed onto the stack. For a halt-mode entry they go into a fixed two-word save area. Last, it fetches the new program counter from the vector and the new status word from vector+2. It then presents the new PC, status word and stack pointer with a one-cycle done strobe. For a halt-mode entry it also raises a strobe that clears any wait state.

Coming out of reset, the block runs a short boot sequence on its own. It reads the selector, loads the PC from that value with its low byte masked off, and writes the selector back with the halt-mode bit set. Requests are accepted only while the sequencer is idle. The request port has no buffering: `req_ready` is high exactly when the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The memory port issues one access at a time. A memory request is held with all its fields unchanged until `mem_req_ready` is seen high, and read data is taken from `mem_rdata` on that same edge.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset is released, the block reads the selector (octal 0177716) and writes back the read value OR octal 010. It then pulses done with new_pc equal to the read value AND octal 0177400. req_ready stays low until that done pulse.
- R2: For kinds 1, 2 and 3, the status word is written to SP-2 and then the PC is written to SP-4, with wrap-around modulo 2^16. new_sp is SP-4.
- R3: Every entry ends with a read of the effective vector, which gives new_pc, and then a read of vector+2, which gives new_psw. done is high in the cycle after the second read is accepted.
- R4: Kind 0 (halt-mode entry) writes selector|010, then writes the PC to octal 0177674 and the status word to octal 0177676. new_sp equals the incoming SP.
- R5: Kind 1 (software trap) writes selector|010 when the vector is at or above octal 0160000, and selector with bit 010 cleared otherwise.
- R6: Kind 2 (illegal instruction or timeout) always writes the selector with bit 010 cleared.
- R7: Kind 3 (halt instruction) ignores req_vector. It uses vector octal 0160002, sets bit 010 and takes the stack push path.
- R8: Each entry begins with a selector read followed by the selector write. Each entry makes exactly six memory accesses, and the boot sequence makes exactly two. A pending memory request keeps its address, direction and write data stable until it is accepted.
- R9: Requests presented while the block is busy are ignored. They change neither the accesses made nor the results of the entry in progress.
- R10: done lasts one cycle per entry. wait_clr is high only together with the done of a kind 0 entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Entry request offered |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_kind | input | 2 | 0 halt-mode, 1 software trap, 2 fault, 3 halt instruction |
| req_vector | input | 16 | Vector address (even) |
| cur_pc | input | 16 | PC to save |
| cur_psw | input | 16 | Status word to save |
| cur_sp | input | 16 | Stack pointer (even) |
| mem_req_valid | output | 1 | Memory access pending |
| mem_req_ready | input | 1 | Memory accepts access this edge |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the accepting cycle |
| new_pc | output | 16 | Loaded program counter |
| new_psw | output | 16 | Loaded status word |
| new_sp | output | 16 | Stack pointer after the entry |
| done | output | 1 | One-cycle completion strobe |
| wait_clr | output | 1 | Clear wait state (halt-mode entry) |

## Verification
The assertions assume that the vector and stack pointer supplied with a request are even, so that every memory address is word-aligned. They also assume the memory side may hold off `mem_req_ready` for any number of cycles, but never changes `mem_rdata` in a way that matters outside the accepting cycle. The stimulus uses only even vectors and stack pointers, including a stack pointer of 2 that wraps. It holds ready low for between zero and three cycles on each access, and changes requests only between clock edges while the block is idle, except in the one test that deliberately offers a request while the block is busy.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    K_HALTMODE = 2'd0,
    K_SWTRAP   = 2'd1,
    K_FAULT    = 2'd2,
    K_HALTINS  = 2'd3
  } entry_kind_e;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_IDLE,
    ST_SEL_RD,
    ST_SEL_WR,
    ST_SAVE_A,
    ST_SAVE_B,
    ST_LD_PC,
    ST_LD_PSW,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/entry_plan.sv
module entry_plan
  import trap_entry_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] HALT_VEC  = 16'o160002,
  parameter logic [W-1:0] HIGH_BASE = 16'o160000
) (
  input  logic [1:0]   kind,
  input  logic [W-1:0] vec,
  output logic         halt_path,
  output logic         sel_set,
  output logic [W-1:0] eff_vec
);
  entry_kind_e k;
  assign k = entry_kind_e'(kind);

  always_comb begin
    eff_vec   = vec;
    halt_path = 1'b0;
    sel_set   = 1'b0;
    case (k)
      K_HALTMODE: begin
        halt_path = 1'b1;
        sel_set   = 1'b1;
      end
      K_SWTRAP:  sel_set = (vec >= HIGH_BASE);
      K_FAULT:   sel_set = 1'b0;
      K_HALTINS: begin
        eff_vec = HALT_VEC;
        sel_set = (HALT_VEC >= HIGH_BASE);
      end
      default:   sel_set = 1'b0;
    endcase
  end
endmodule

// File: rtl/entry_addr.sv
module entry_addr
  import trap_entry_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] SEL_ADDR  = 16'o177716,
  parameter logic [W-1:0] SAVE_ADDR = 16'o177674,
  parameter logic [W-1:0] HALT_BIT  = 16'o10
) (
  input  seq_state_e   st,
  input  logic         halt_q,
  input  logic         set_q,
  input  logic [W-1:0] sp_q,
  input  logic [W-1:0] pc_q,
  input  logic [W-1:0] psw_q,
  input  logic [W-1:0] vec_q,
  input  logic [W-1:0] sel_q,
  output logic         valid,
  output logic         we,
  output logic [W-1:0] addr,
  output logic [W-1:0] wdata
);
  localparam logic [W-1:0] TWO     = W'(2);
  localparam logic [W-1:0] FOUR    = W'(4);
  localparam logic [W-1:0] SAVE_HI = SAVE_ADDR + TWO;

  always_comb begin
    valid = 1'b1;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (st)
      ST_SEL_RD: addr = SEL_ADDR;
      ST_SEL_WR: begin
        we    = 1'b1;
        addr  = SEL_ADDR;
        wdata = set_q ? (sel_q | HALT_BIT) : (sel_q & ~HALT_BIT);
      end
      ST_SAVE_A: begin
        we    = 1'b1;
        addr  = halt_q ? SAVE_ADDR : (sp_q - TWO);
        wdata = halt_q ? pc_q : psw_q;
      end
      ST_SAVE_B: begin
        we    = 1'b1;
        addr  = halt_q ? SAVE_HI : (sp_q - FOUR);
        wdata = halt_q ? psw_q : pc_q;
      end
      ST_LD_PC:  addr = vec_q;
      ST_LD_PSW: addr = vec_q + TWO;
      default:   valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] SEL_ADDR  = 16'o177716,
  parameter logic [W-1:0] SAVE_ADDR = 16'o177674,
  parameter logic [W-1:0] HALT_BIT  = 16'o10,
  parameter logic [W-1:0] BOOT_MASK = 16'o177400,
  parameter logic [W-1:0] HALT_VEC  = 16'o160002,
  parameter logic [W-1:0] HIGH_BASE = 16'o160000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_kind,
  input  logic [W-1:0] req_vector,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] cur_psw,
  input  logic [W-1:0] cur_sp,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] new_pc,
  output logic [W-1:0] new_psw,
  output logic [W-1:0] new_sp,
  output logic         done,
  output logic         wait_clr
);
  localparam logic [W-1:0] FOUR = W'(4);

  seq_state_e   st;
  logic         boot_q, halt_q, set_q;
  logic [W-1:0] vec_q, pc_q, psw_q, sp_q, sel_q;
  logic         pl_halt, pl_set;
  logic [W-1:0] pl_vec;
  logic         hs;

  entry_plan #(.W(W), .HALT_VEC(HALT_VEC), .HIGH_BASE(HIGH_BASE)) u_plan (
    .kind(req_kind), .vec(req_vector),
    .halt_path(pl_halt), .sel_set(pl_set), .eff_vec(pl_vec)
  );

  entry_addr #(.W(W), .SEL_ADDR(SEL_ADDR), .SAVE_ADDR(SAVE_ADDR), .HALT_BIT(HALT_BIT)) u_addr (
    .st(st), .halt_q(halt_q), .set_q(set_q), .sp_q(sp_q), .pc_q(pc_q),
    .psw_q(psw_q), .vec_q(vec_q), .sel_q(sel_q),
    .valid(mem_req_valid), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );

  assign hs = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RESET;
      boot_q <= 1'b1;
      halt_q <= 1'b0;
      set_q  <= 1'b1;
      vec_q  <= '0;
      pc_q   <= '0;
      psw_q  <= '0;
      sp_q   <= '0;
      sel_q  <= '0;
    end else begin
      case (st)
        ST_RESET: st <= ST_SEL_RD;
        ST_IDLE: if (req_valid) begin
          boot_q <= 1'b0;
          halt_q <= pl_halt;
          set_q  <= pl_set;
          vec_q  <= pl_vec;
          pc_q   <= cur_pc;
          psw_q  <= cur_psw;
          sp_q   <= cur_sp;
          st     <= ST_SEL_RD;
        end
        ST_SEL_RD: if (hs) begin
          sel_q <= mem_rdata;
          st    <= ST_SEL_WR;
        end
        ST_SEL_WR: if (hs) begin
          if (boot_q) begin
            pc_q <= sel_q & BOOT_MASK;
            st   <= ST_DONE;
          end else begin
            st <= ST_SAVE_A;
          end
        end
        ST_SAVE_A: if (hs) st <= ST_SAVE_B;
        ST_SAVE_B: if (hs) begin
          if (!halt_q) sp_q <= sp_q - FOUR;
          st <= ST_LD_PC;
        end
        ST_LD_PC: if (hs) begin
          pc_q <= mem_rdata;
          st   <= ST_LD_PSW;
        end
        ST_LD_PSW: if (hs) begin
          psw_q <= mem_rdata;
          st    <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign done      = (st == ST_DONE);
  assign wait_clr  = done && halt_q && !boot_q;
  assign new_pc    = pc_q;
  assign new_psw   = psw_q;
  assign new_sp    = sp_q;

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata));

  // R8
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_addr[0]);

  // R8
  first_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req_valid && !mem_we && mem_addr == SEL_ADDR);

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  wait_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_clr |-> done && !mem_req_valid);
endmodule

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEL = 16'o177716;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_vector = '0, cur_pc = '0, cur_psw = '0, cur_sp = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] new_pc, new_psw, new_sp;
  logic done, wait_clr;

  int n_chk = 0, n_bad = 0;
  logic [15:0] dip_r = 16'h0000;
  int cur_lat = 0, stall = 0;
  logic [32:0] log_e [8];
  logic [32:0] ex [6];
  int log_n = 0, done_n = 0;
  logic [15:0] cap_pc, cap_psw, cap_sp;
  logic cap_wc;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_vector(req_vector), .cur_pc(cur_pc),
    .cur_psw(cur_psw), .cur_sp(cur_sp), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .new_pc(new_pc),
    .new_psw(new_psw), .new_sp(new_sp), .done(done), .wait_clr(wait_clr)
  );

  assign mem_rdata = (mem_addr == SEL) ? dip_r : (mem_addr ^ 16'h5A5A);

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      stall = 0;
    end else if (mem_req_valid) begin
      if (stall >= cur_lat) begin
        mem_req_ready = 1'b1;
        if (log_n < 8) log_e[log_n] = {mem_we, mem_addr, mem_we ? mem_wdata : 16'h0};
        log_n = log_n + 1;
        stall = 0;
      end else begin
        mem_req_ready = 1'b0;
        stall = stall + 1;
      end
    end else begin
      mem_req_ready = 1'b0;
    end
    if (rst_n && done) begin
      done_n = done_n + 1;
      cap_pc = new_pc; cap_psw = new_psw; cap_sp = new_sp; cap_wc = wait_clr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_n == 0; i++) @(negedge clk);
  endtask

  // vector layout: lat[87:84] kind[81:80] vec pc psw sp dip
  localparam logic [87:0] TV [7] = '{
    {4'd0, 4'd0, 16'o000100, 16'h1234, 16'h00E0, 16'h1000, 16'h8001},
    {4'd1, 4'd1, 16'o000030, 16'h2222, 16'h0011, 16'h0800, 16'h800F},
    {4'd2, 4'd1, 16'o160000, 16'h3330, 16'h0002, 16'h0400, 16'h8000},
    {4'd0, 4'd1, 16'o157776, 16'h4444, 16'h0004, 16'h0600, 16'hFFFF},
    {4'd3, 4'd2, 16'o000004, 16'h5550, 16'h0008, 16'h0A00, 16'h00FF},
    {4'd1, 4'd3, 16'o000040, 16'h6660, 16'h0010, 16'h0002, 16'h0000},
    {4'd2, 4'd0, 16'o000270, 16'h7770, 16'h0080, 16'h0C00, 16'h1234}
  };

  task automatic run_entry(input logic [1:0] k, input logic [15:0] v, input logic [15:0] pc,
                           input logic [15:0] psw, input logic [15:0] sp, input logic [15:0] dip,
                           input int lat, input bit poke_busy, input string tag);
    bit halt, setb;
    logic [15:0] ev, selw;
    for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
    dip_r = dip; cur_lat = lat; log_n = 0; done_n = 0;
    req_kind = k; req_vector = v; cur_pc = pc; cur_psw = psw; cur_sp = sp;
    req_valid = 1'b1;
    @(negedge clk);
    if (poke_busy) begin
      req_kind = 2'd0; req_vector = 16'o000200; cur_pc = 16'hDEAD; cur_psw = 16'h00FF; cur_sp = 16'h2000;
      for (int i = 0; i < 3; i++) begin
        chk(!req_ready, {tag, " R9 ready low while busy"}, {32'h0, req_ready}, 33'h0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    wait_done();
    halt = (k == 2'd0);
    setb = (k == 2'd0) || (k == 2'd3) || (k == 2'd1 && v >= 16'o160000);
    ev   = (k == 2'd3) ? 16'o160002 : v;
    selw = setb ? (dip | 16'o10) : (dip & ~16'o10);
    ex[0] = {1'b0, SEL, 16'h0};
    ex[1] = {1'b1, SEL, selw};
    ex[2] = halt ? {1'b1, 16'o177674, pc}  : {1'b1, sp - 16'd2, psw};
    ex[3] = halt ? {1'b1, 16'o177676, psw} : {1'b1, sp - 16'd4, pc};
    ex[4] = {1'b0, ev, 16'h0};
    ex[5] = {1'b0, ev + 16'd2, 16'h0};
    chk(log_n == 6, {tag, " R8 access count"}, 33'(log_n), 33'd6);
    chk(log_e[1] == ex[1], {tag, " R5 R6 R7 selector write"}, log_e[1], ex[1]);
    chk(log_e[0] == ex[0], {tag, " R8 selector read first"}, log_e[0], ex[0]);
    chk(log_e[2] == ex[2], {tag, " R2 R4 first save"}, log_e[2], ex[2]);
    chk(log_e[3] == ex[3], {tag, " R2 R4 second save"}, log_e[3], ex[3]);
    chk(log_e[4] == ex[4] && log_e[5] == ex[5], {tag, " R3 R7 vector reads"}, log_e[4], ex[4]);
    chk(done_n == 1, {tag, " R10 one done"}, 33'(done_n), 33'd1);
    chk(cap_pc == (ev ^ 16'h5A5A), {tag, " R3 new_pc"}, {17'h0, cap_pc}, {17'h0, ev ^ 16'h5A5A});
    chk(cap_psw == ((ev + 16'd2) ^ 16'h5A5A), {tag, " R3 new_psw"}, {17'h0, cap_psw}, {17'h0, (ev + 16'd2) ^ 16'h5A5A});
    chk(cap_sp == (halt ? sp : sp - 16'd4), {tag, " R2 R4 new_sp"}, {17'h0, cap_sp}, {17'h0, halt ? sp : sp - 16'd4});
    chk(cap_wc == halt, {tag, " R10 wait_clr"}, {32'h0, cap_wc}, {32'h0, halt});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk = n_chk + 1; n_bad = n_bad + 1;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    dip_r = 16'hA5C3; cur_lat = 1;
    repeat (3) @(negedge clk);
    chk(!req_ready && !done && !mem_req_valid, "R1 reset state",
        {30'h0, req_ready, done, mem_req_valid}, 33'h0);
    log_n = 0; done_n = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1 not ready during boot", {32'h0, req_ready}, 33'h0);
    wait_done();
    chk(log_n == 2, "R1 R8 boot access count", 33'(log_n), 33'd2);
    chk(log_e[0] == {1'b0, SEL, 16'h0}, "R1 boot selector read", log_e[0], {1'b0, SEL, 16'h0});
    chk(log_e[1] == {1'b1, SEL, 16'hA5CB}, "R1 boot selector write", log_e[1], {1'b1, SEL, 16'hA5CB});
    chk(cap_pc == 16'hA500, "R1 boot pc", {17'h0, cap_pc}, {17'h0, 16'hA500});
    chk(cap_wc == 1'b0, "R10 no wait_clr at boot", {32'h0, cap_wc}, 33'h0);

    for (int t = 0; t < 7; t++) begin
      run_entry(TV[t][81:80], TV[t][79:64], TV[t][63:48], TV[t][47:32], TV[t][31:16],
                TV[t][15:0], int'(TV[t][87:84]), 1'b0, $sformatf("vec%0d", t));
    end

    // R9: a request offered while busy must not disturb the entry in progress
    run_entry(2'd1, 16'o000060, 16'h1110, 16'h0001, 16'h0E00, 16'h0008, 1, 1'b1, "busy");
    repeat (4) @(negedge clk);
    chk(done_n == 1 && log_n == 6, "R9 ignored request not replayed", 33'(log_n), 33'd6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule